// File: doc/BRIEF.md
# Wavefront Lane Identifier Generator

This block turns a wavefront index and the three effective workgroup extents into the per-lane coordinates a freshly launched wavefront needs. For each lane it streams out the x, y and z work-item coordinates, the flattened work-item number and whether the lane holds real work. After the last lane it presents the packed activity word, the count of live lanes in this wavefront (its spill width) and the number of wavefronts the whole workgroup spans (its barrier slot count).

A single-cycle `start` pulse, accepted only while the block is idle, captures the index and extents. A shared shift-and-subtract divider then splits the first lane's linear position into x, y and z seeds in two passes. Lanes then leave at one per clock. A three-level wrap-and-carry counter advances the coordinates, so no divider sits in the lane loop. `done` pulses for one cycle after the final lane. The lane count per wavefront is a power-of-two parameter (64 by default), and each extent is a 10-bit value from 1 to 1023.

Top module: `wave_id_gen`

## Requirements
- R1: After reset `busy`, `lane_valid` and `done` are all 0.
- R2: Every accepted start produces exactly LANES cycles with `lane_valid` high. These cycles are consecutive, and `lane_idx` runs 0, 1, … LANES-1 across them.
- R3: For lane k with linear position L = k + wave_idx·LANES, the bench expects `id_x` = L mod size_x, `id_y` = (L div size_x) mod size_y and `id_z` = L div (size_x·size_y). This holds for inactive lanes too.
- R4: `flat_id` equals id_z·size_x·size_y + id_y·size_x + id_x, which is the linear position L.
- R5: `lane_active` is 1 exactly when L < size_x·size_y·size_z. When `done` is high, bit k of `lane_mask` holds that flag for lane k.
- R6: While `done` is high, `spill_width` is LANES when (wave_idx+1)·LANES < total. Otherwise it is total − wave_idx·LANES, clamped to 0 when that difference is not positive.
- R7: While `done` is high, `barrier_slots` equals ceil(total / LANES).
- R8: `done` is high for exactly the cycle after the lane with index LANES-1, with `lane_valid` low. `busy` is low in the cycle after that.
- R9: A `start` pulse while `busy` is high is ignored. The running wavefront keeps its captured parameters, and no further lanes follow its `done`.
- R10: Whenever `lane_valid` is high, `id_x` < size_x and `id_y` < size_y for the captured extents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, honoured only when idle |
| wave_idx | input | 26 | Wavefront index inside the workgroup |
| size_x | input | 10 | Effective workgroup extent in x (1..1023) |
| size_y | input | 10 | Effective workgroup extent in y (1..1023) |
| size_z | input | 10 | Effective workgroup extent in z (1..1023) |
| busy | output | 1 | High from the cycle after an accepted start through `done` |
| lane_valid | output | 1 | Lane fields are valid this cycle |
| lane_idx | output | 6 | Lane number within the wavefront |
| lane_active | output | 1 | Lane's linear position is inside the workgroup |
| id_x | output | 10 | Work-item x coordinate |
| id_y | output | 10 | Work-item y coordinate |
| id_z | output | 32 | Work-item z coordinate (may exceed size_z on inactive lanes) |
| flat_id | output | 32 | Flattened work-item number |
| done | output | 1 | One-cycle completion pulse |
| lane_mask | output | 64 | Packed activity flags, bit k for lane k |
| spill_width | output | 7 | Live lanes in this wavefront |
| barrier_slots | output | 27 | Wavefronts needed for the whole workgroup |

## Verification
A wrong seed from either divider pass shows at the ports in the first `lane_valid` cycle, as an x, y or z that disagrees with the modular decomposition of the first linear position. A carry fault in the coordinate counter shows in the first lane where x or y should wrap. An activity-flag or mask-register fault shows in `lane_active` on the boundary lane, or in `lane_mask` in the `done` cycle. Width and slot faults can only be seen in that same `done` cycle. For this reason every scenario is chosen so that it crosses a wrap, a partial-wave boundary or an empty wave within its 64 lanes.

// File: rtl/wig_pkg.sv
package wig_pkg;

    parameter int LANES = 64;
    parameter int DIM_W = 10;
    parameter int LIN_W = 32;

    localparam int LANE_W  = $clog2(LANES);
    localparam int IDX_W   = LIN_W - LANE_W;
    localparam int SPILL_W = LANE_W + 1;
    localparam int SLOT_W  = LIN_W - LANE_W + 1;

    typedef logic [DIM_W-1:0] dim_t;
    typedef logic [LIN_W-1:0] lin_t;

    typedef struct packed {
        dim_t sx;
        dim_t sy;
        dim_t sz;
    } shape_t;

    typedef struct packed {
        dim_t x;
        dim_t y;
        lin_t z;
    } coord_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DIVX,
        PH_DIVY,
        PH_EMIT,
        PH_FIN
    } phase_t;

    // Increment v; return {carry, next} with next wrapped to 0 at lim.
    function automatic logic [DIM_W:0] wrap_inc(input dim_t v, input dim_t lim);
        logic [DIM_W:0] nxt;
        nxt = {1'b0, v} + (DIM_W+1)'(1);
        if (nxt >= {1'b0, lim})
            return {1'b1, {DIM_W{1'b0}}};
        return {1'b0, nxt[DIM_W-1:0]};
    endfunction

endpackage

// File: rtl/wig_serial_div.sv
module wig_serial_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot,
    output logic [DEN_W-1:0] rem
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] work;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt;
    logic             running;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             ge;

    always_comb begin
        trial = {rem, work[NUM_W-1]};
        ge    = trial >= {1'b0, den_q};
        diff  = trial - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work    <= '0;
            den_q   <= '0;
            cnt     <= '0;
            running <= 1'b0;
            done    <= 1'b0;
            quot    <= '0;
            rem     <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                work    <= num;
                den_q   <= den;
                quot    <= '0;
                rem     <= '0;
                cnt     <= CNT_W'(NUM_W);
                running <= 1'b1;
            end else if (running) begin
                work <= {work[NUM_W-2:0], 1'b0};
                quot <= {quot[NUM_W-2:0], ge};
                rem  <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                cnt  <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wig_wave_span.sv
module wig_wave_span
    import wig_pkg::*;
(
    input  logic [IDX_W-1:0]   wave_idx,
    input  shape_t             shape,
    output lin_t               base_lin,
    output lin_t               total,
    output logic [SPILL_W-1:0] spill,
    output logic [SLOT_W-1:0]  slots
);
    logic [LIN_W:0] wave_end;
    logic [LIN_W:0] rounded;

    always_comb begin
        base_lin = {wave_idx, {LANE_W{1'b0}}};
        total    = lin_t'(shape.sx) * lin_t'(shape.sy) * lin_t'(shape.sz);
        wave_end = {1'b0, base_lin} + (LIN_W+1)'(LANES);
        if (wave_end >= {1'b0, total}) begin
            if (total > base_lin)
                spill = SPILL_W'(total - base_lin);
            else
                spill = '0;
        end else begin
            spill = SPILL_W'(LANES);
        end
        rounded = {1'b0, total} + (LIN_W+1)'(LANES - 1);
        slots   = SLOT_W'(rounded >> LANE_W);
    end
endmodule

// File: rtl/wig_coord_walk.sv
module wig_coord_walk
    import wig_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   step,
    input  coord_t seed,
    input  lin_t   seed_lin,
    input  dim_t   lim_x,
    input  dim_t   lim_y,
    output coord_t pos,
    output lin_t   lin
);
    logic [DIM_W:0] x_nxt;
    logic [DIM_W:0] y_nxt;
    coord_t         pos_nxt;

    always_comb begin
        x_nxt   = wrap_inc(pos.x, lim_x);
        y_nxt   = wrap_inc(pos.y, lim_y);
        pos_nxt = pos;
        pos_nxt.x = x_nxt[DIM_W-1:0];
        if (x_nxt[DIM_W]) begin
            pos_nxt.y = y_nxt[DIM_W-1:0];
            if (y_nxt[DIM_W])
                pos_nxt.z = pos.z + lin_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            lin <= '0;
        end else if (load) begin
            pos <= seed;
            lin <= seed_lin;
        end else if (step) begin
            pos <= pos_nxt;
            lin <= lin + lin_t'(1);
        end
    end
endmodule

// File: rtl/wave_id_gen.sv
module wave_id_gen
    import wig_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [wig_pkg::IDX_W-1:0] wave_idx,
    input  logic [wig_pkg::DIM_W-1:0] size_x,
    input  logic [wig_pkg::DIM_W-1:0] size_y,
    input  logic [wig_pkg::DIM_W-1:0] size_z,
    output logic                      busy,
    output logic                      lane_valid,
    output logic [wig_pkg::LANE_W-1:0] lane_idx,
    output logic                      lane_active,
    output logic [wig_pkg::DIM_W-1:0] id_x,
    output logic [wig_pkg::DIM_W-1:0] id_y,
    output logic [wig_pkg::LIN_W-1:0] id_z,
    output logic [wig_pkg::LIN_W-1:0] flat_id,
    output logic                      done,
    output logic [wig_pkg::LANES-1:0] lane_mask,
    output logic [wig_pkg::SPILL_W-1:0] spill_width,
    output logic [wig_pkg::SLOT_W-1:0]  barrier_slots
);
    phase_t              phase;
    shape_t              shape_in;
    shape_t              shape_q;
    lin_t                total_q;
    lin_t                base_q;
    logic [SPILL_W-1:0]  spill_q;
    logic [SLOT_W-1:0]   slots_q;
    dim_t                x_seed_q;
    logic [LANE_W-1:0]   lane_q;
    logic [LANES-1:0]    mask_q;

    lin_t                span_base;
    lin_t                span_total;
    logic [SPILL_W-1:0]  span_spill;
    logic [SLOT_W-1:0]   span_slots;

    logic                accept;
    logic                div_start;
    lin_t                div_num;
    dim_t                div_den;
    logic                div_done;
    lin_t                div_quot;
    dim_t                div_rem;

    logic                walk_load;
    logic                walk_step;
    coord_t              walk_seed;
    coord_t              walk_pos;
    lin_t                walk_lin;

    assign shape_in = '{sx: size_x, sy: size_y, sz: size_z};
    assign accept   = start && (phase == PH_IDLE);

    wig_wave_span u_span (
        .wave_idx (wave_idx),
        .shape    (shape_in),
        .base_lin (span_base),
        .total    (span_total),
        .spill    (span_spill),
        .slots    (span_slots)
    );

    // Pass 1 splits the base position by x; pass 2 splits its quotient by y.
    always_comb begin
        div_start = accept || ((phase == PH_DIVX) && div_done);
        div_num   = (phase == PH_IDLE) ? span_base : div_quot;
        div_den   = (phase == PH_IDLE) ? size_x : shape_q.sy;
    end

    wig_serial_div #(
        .NUM_W (LIN_W),
        .DEN_W (DIM_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quot  (div_quot),
        .rem   (div_rem)
    );

    always_comb begin
        walk_load   = (phase == PH_DIVY) && div_done;
        walk_step   = (phase == PH_EMIT);
        walk_seed   = '{x: x_seed_q, y: div_rem, z: div_quot};
    end

    wig_coord_walk u_walk (
        .clk      (clk),
        .rst      (rst),
        .load     (walk_load),
        .step     (walk_step),
        .seed     (walk_seed),
        .seed_lin (base_q),
        .lim_x    (shape_q.sx),
        .lim_y    (shape_q.sy),
        .pos      (walk_pos),
        .lin      (walk_lin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            shape_q  <= '0;
            total_q  <= '0;
            base_q   <= '0;
            spill_q  <= '0;
            slots_q  <= '0;
            x_seed_q <= '0;
            lane_q   <= '0;
            mask_q   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        shape_q <= shape_in;
                        total_q <= span_total;
                        base_q  <= span_base;
                        spill_q <= span_spill;
                        slots_q <= span_slots;
                        phase   <= PH_DIVX;
                    end
                end
                PH_DIVX: begin
                    if (div_done) begin
                        x_seed_q <= div_rem;
                        phase    <= PH_DIVY;
                    end
                end
                PH_DIVY: begin
                    if (div_done) begin
                        lane_q <= '0;
                        mask_q <= '0;
                        phase  <= PH_EMIT;
                    end
                end
                PH_EMIT: begin
                    mask_q[lane_q] <= lane_active;
                    lane_q         <= lane_q + LANE_W'(1);
                    if (lane_q == LANE_W'(LANES - 1))
                        phase <= PH_FIN;
                end
                PH_FIN: begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy          = (phase != PH_IDLE);
        lane_valid    = (phase == PH_EMIT);
        done          = (phase == PH_FIN);
        lane_idx      = lane_q;
        lane_active   = walk_lin < total_q;
        id_x          = walk_pos.x;
        id_y          = walk_pos.y;
        id_z          = walk_pos.z;
        flat_id       = walk_lin;
        lane_mask     = mask_q;
        spill_width   = spill_q;
        barrier_slots = slots_q;
    end
endmodule

// File: rtl/wave_id_gen_checks.sv
module wave_id_gen_checks
    import wig_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [DIM_W-1:0]   size_x,
    input logic [DIM_W-1:0]   size_y,
    input logic               busy,
    input logic               lane_valid,
    input logic [LANE_W-1:0]  lane_idx,
    input logic               lane_active,
    input logic [DIM_W-1:0]   id_x,
    input logic [LIN_W-1:0]   flat_id,
    input logic               done,
    input logic [LANES-1:0]   lane_mask,
    input logic [DIM_W-1:0]   id_y
);
    localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

    logic [DIM_W-1:0] cap_x;
    logic [DIM_W-1:0] cap_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_x <= '0;
            cap_y <= '0;
        end else if (start && !busy) begin
            cap_x <= size_x;
            cap_y <= size_y;
        end
    end

    // R2
    lane_step_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_valid && lane_idx != LAST) |=> (lane_valid && lane_idx == $past(lane_idx) + LANE_W'(1)));

    // R2
    lane_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lane_valid) |-> (lane_idx == '0));

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_valid && lane_idx == LAST) |=> (done && !lane_valid));

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10
    coord_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lane_valid |-> (id_x < cap_x && id_y < cap_y));

    // R3
    x_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_valid && $past(lane_valid)) |->
            (({1'b0, $past(id_x)} + (DIM_W+1)'(1) == {1'b0, cap_x}) ? (id_x == '0)
                                                                    : (id_x == $past(id_x) + DIM_W'(1))));

    // R4
    flat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_valid && $past(lane_valid)) |-> (flat_id == $past(flat_id) + LIN_W'(1)));

    // R5
    mask_tail_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lane_mask[LANES-1] == $past(lane_active)));
endmodule

bind wave_id_gen wave_id_gen_checks u_checks (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .size_x      (size_x),
    .size_y      (size_y),
    .busy        (busy),
    .lane_valid  (lane_valid),
    .lane_idx    (lane_idx),
    .lane_active (lane_active),
    .id_x        (id_x),
    .flat_id     (flat_id),
    .done        (done),
    .lane_mask   (lane_mask),
    .id_y        (id_y)
);

// File: tb/wave_id_gen_test.sv
module wave_id_gen_test;
    import wig_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [IDX_W-1:0]    wave_idx = '0;
    logic [DIM_W-1:0]    size_x = DIM_W'(1);
    logic [DIM_W-1:0]    size_y = DIM_W'(1);
    logic [DIM_W-1:0]    size_z = DIM_W'(1);
    logic                busy;
    logic                lane_valid;
    logic [LANE_W-1:0]   lane_idx;
    logic                lane_active;
    logic [DIM_W-1:0]    id_x;
    logic [DIM_W-1:0]    id_y;
    logic [LIN_W-1:0]    id_z;
    logic [LIN_W-1:0]    flat_id;
    logic                done;
    logic [LANES-1:0]    lane_mask;
    logic [SPILL_W-1:0]  spill_width;
    logic [SLOT_W-1:0]   barrier_slots;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    wave_id_gen uut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .wave_idx      (wave_idx),
        .size_x        (size_x),
        .size_y        (size_y),
        .size_z        (size_z),
        .busy          (busy),
        .lane_valid    (lane_valid),
        .lane_idx      (lane_idx),
        .lane_active   (lane_active),
        .id_x          (id_x),
        .id_y          (id_y),
        .id_z          (id_z),
        .flat_id       (flat_id),
        .done          (done),
        .lane_mask     (lane_mask),
        .spill_width   (spill_width),
        .barrier_slots (barrier_slots)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog (R2): ran %0d cycles, expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", longint'(busy), 0);
        chk(lane_valid == 1'b0, "R1", "lane_valid after reset", longint'(lane_valid), 0);
        chk(done == 1'b0, "R1", "done after reset", longint'(done), 0);
    endtask

    // Launch one wavefront and check every lane plus the completion data.
    // With poke set, a second start with other values is raised while busy (R9).
    task automatic run_wave(input longint idx, input longint sx, input longint sy,
                            input longint sz, input bit poke);
        longint total, base, lin, ex, ey, ez, exp_spill, exp_slots;
        logic [LANES-1:0] exp_mask;
        int k;
        bit seen_done;
        total = sx * sy * sz;
        base  = idx * LANES;
        exp_mask = '0;
        k = 0;
        seen_done = 1'b0;
        if (base + LANES >= total)
            exp_spill = (total > base) ? total - base : 0;
        else
            exp_spill = LANES;
        exp_slots = (total + LANES - 1) / LANES;

        @(negedge clk);
        wave_idx = IDX_W'(idx);
        size_x = DIM_W'(sx);
        size_y = DIM_W'(sy);
        size_z = DIM_W'(sz);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            wave_idx = IDX_W'(idx + 5);
            size_x = DIM_W'(3);
            size_y = DIM_W'(2);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 400; t++) begin
            if (lane_valid) begin
                lin = base + k;
                ex = lin % sx;
                ey = (lin / sx) % sy;
                ez = lin / (sx * sy);
                chk(lane_idx == LANE_W'(k), "R2", "lane index", longint'(lane_idx), k);
                chk(id_x == DIM_W'(ex), "R3", "id_x", longint'(id_x), ex);
                chk(id_y == DIM_W'(ey), "R3", "id_y", longint'(id_y), ey);
                chk(id_z == LIN_W'(ez), "R3", "id_z", longint'(id_z), ez);
                chk(flat_id == LIN_W'(ez * sx * sy + ey * sx + ex), "R4", "flat_id",
                    longint'(flat_id), ez * sx * sy + ey * sx + ex);
                chk(lane_active == (lin < total), "R5", "lane_active",
                    longint'(lane_active), longint'(lin < total));
                exp_mask[k] = (lin < total);
                k = k + 1;
            end
            if (done) begin
                seen_done = 1'b1;
                chk(k == LANES, "R2", "lanes before done", k, LANES);
                chk(lane_valid == 1'b0, "R8", "lane_valid during done", longint'(lane_valid), 0);
                chk(lane_mask == exp_mask, "R5", "lane_mask", longint'(lane_mask), longint'(exp_mask));
                chk(spill_width == SPILL_W'(exp_spill), "R6", "spill_width",
                    longint'(spill_width), exp_spill);
                chk(barrier_slots == SLOT_W'(exp_slots), "R7", "barrier_slots",
                    longint'(barrier_slots), exp_slots);
                break;
            end
            @(negedge clk);
        end
        chk(seen_done, "R8", "done seen", longint'(seen_done), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R8", "busy after done", longint'(busy), 0);
        if (poke) begin
            for (int t = 0; t < 4; t++) begin
                chk(!busy && !lane_valid, "R9", "activity after ignored start",
                    longint'({busy, lane_valid}), 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        check_reset();
        run_wave(0, 4, 4, 8, 1'b0);     // full wave, R5 all lanes live
        run_wave(1, 5, 3, 7, 1'b0);     // partial last wave: spill 41, R6
        run_wave(3, 5, 3, 7, 1'b0);     // wave past the end: spill 0, empty mask
        run_wave(15, 1023, 2, 1, 1'b0); // x wraps at 1023 inside the wave, R10
        run_wave(0, 1, 1, 1, 1'b0);     // single item, y and z carry every lane
        run_wave(1, 7, 9, 2, 1'b1);     // start while busy ignored, R9
        run_wave(1, 3, 2, 20, 1'b0);    // fast y wrap, R7 slots 2
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule